// File: doc/BRIEF.md
# Serial Port Interrupt Request Hub

This block collects the status flags of a three-channel asynchronous serial port and turns them into interrupt requests and transfer-engine requests. Each channel keeps six sticky flags: overrun, parity error, framing error, receive full, transmit empty and transmit end. The serial datapath raises them with one-cycle set pulses. Software lowers them with one-cycle clear pulses. Per-channel enable levels gate the flags into four request sources per channel: receive error, receive full, transmit empty and transmit end.

Only the receive-full and transmit-empty sources drive a request toward an external data-transfer engine. That request uses a req/ack handshake. When the engine acknowledges an active request, the hub clears the matching flag by itself. All twelve request sources are merged by fixed priority into a single registered vector index with a valid strobe, which an interrupt controller can consume directly.

Top module: `uart_irq_hub`

## Requirements
- R1: After synchronous reset, every flag, interrupt output, transfer request, `irq_valid` and `irq_vec` is 0.
- R2: A set pulse makes its flag 1 from the next clock, and a clear pulse makes it 0. When a set and a clear hit the same flag in one cycle, the flag ends up 1.
- R3: `irq_txe[c]` is 1 exactly while the transmit-empty flag is 1 and `en_txe[c]` was 1. `irq_rxf[c]` is 1 exactly while the receive-full flag is 1 and `en_rx[c]` was 1.
- R4: `irq_txd[c]` is 1 only while both the transmit-end flag and `en_txd[c]` are 1. `en_txe` has no influence on it.
- R5: `irq_err[c]` is the OR of the overrun, parity and framing flags, gated by `en_rx[c]`.
- R6: Transfer requests exist only for receive full (`rxf_req`) and transmit empty (`txe_req`), and each follows its interrupt source. Error and transmit-end flags never raise either request.
- R7: An ack sampled while its request is 1 clears the flag on that clock edge, and the request is 0 from the same edge. An ack while the request is 0 leaves the flag unchanged.
- R8: A set pulse coinciding with an accepted ack leaves the flag and its request at 1.
- R9: `irq_valid` is 1 while any interrupt source is pending. `irq_vec` is then channel×4 + source code, with source codes receive error 0, receive full 1, transmit empty 2, transmit end 3, and the lowest index pending wins.
- R10: When transmit empty and transmit end of one channel are both pending, the vector names transmit empty (code 2).
- R11: Clearing the transmit-empty and transmit-end flags of a channel in the same cycle leaves no transmit-end request afterwards.
- R12: Channel 0 outranks channel 1, and channel 1 outranks channel 2, whatever their sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_ovr | input | NCH | Overrun flag set pulses |
| set_par | input | NCH | Parity-error flag set pulses |
| set_frm | input | NCH | Framing-error flag set pulses |
| set_rxf | input | NCH | Receive-full flag set pulses |
| set_txe | input | NCH | Transmit-empty flag set pulses |
| set_txd | input | NCH | Transmit-end flag set pulses |
| clr_ovr | input | NCH | Software clear of overrun flags |
| clr_par | input | NCH | Software clear of parity flags |
| clr_frm | input | NCH | Software clear of framing flags |
| clr_rxf | input | NCH | Software clear of receive-full flags |
| clr_txe | input | NCH | Software clear of transmit-empty flags |
| clr_txd | input | NCH | Software clear of transmit-end flags |
| en_rx | input | NCH | Enable for receive full and receive error |
| en_txe | input | NCH | Enable for transmit empty |
| en_txd | input | NCH | Enable for transmit end |
| rxf_ack | input | NCH | Transfer engine ack for receive full |
| txe_ack | input | NCH | Transfer engine ack for transmit empty |
| flg_ovr | output | NCH | Overrun flags |
| flg_par | output | NCH | Parity flags |
| flg_frm | output | NCH | Framing flags |
| flg_rxf | output | NCH | Receive-full flags |
| flg_txe | output | NCH | Transmit-empty flags |
| flg_txd | output | NCH | Transmit-end flags |
| irq_err | output | NCH | Receive-error interrupt requests |
| irq_rxf | output | NCH | Receive-full interrupt requests |
| irq_txe | output | NCH | Transmit-empty interrupt requests |
| irq_txd | output | NCH | Transmit-end interrupt requests |
| rxf_req | output | NCH | Transfer engine requests for receive full |
| txe_req | output | NCH | Transfer engine requests for transmit empty |
| irq_valid | output | 1 | Any interrupt pending |
| irq_vec | output | $clog2(NCH*4) | Winning source index |

## Verification
The checker watches several rules on every cycle: the enable gating of each source, set pulses beating clears and acks, flag and request dropping after an accepted ack, acks without a request being ignored, and the paired clear leaving no transmit-end request. It also checks that the vector always names a pending source with nothing lower pending, and that transmit end is never chosen while transmit empty of the same channel is up. Only the bench scenarios show the concrete vector values as sources of different channels come and go. They also show that the error and transmit-end flags never reach the transfer requests, and that the exact cycle at which each output moves matches the requirements.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_PER_CH = 4;
  localparam int FLAG_CNT   = 6;

  // source order inside a channel is the priority order
  localparam int SRC_ERR = 0;
  localparam int SRC_RXF = 1;
  localparam int SRC_TXE = 2;
  localparam int SRC_TXD = 3;

  // flag slots inside a channel
  localparam int F_OVR = 0;
  localparam int F_PAR = 1;
  localparam int F_FRM = 2;
  localparam int F_RXF = 3;
  localparam int F_TXE = 4;
  localparam int F_TXD = 5;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_p,
  input  logic clr_p,
  input  logic ack_p,
  output logic nxt,
  output logic q
);
  // a set always wins over either kind of clear
  always_comb nxt = set_p | (q & ~clr_p & ~ack_p);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/uart_irq_chan.sv
module uart_irq_chan
  import uart_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FLAG_CNT-1:0]   set_v,
  input  logic [FLAG_CNT-1:0]   clr_v,
  input  logic                  en_rx,
  input  logic                  en_txe,
  input  logic                  en_txd,
  input  logic                  rxf_ack,
  input  logic                  txe_ack,
  output logic [FLAG_CNT-1:0]   flg,
  output logic [SRC_PER_CH-1:0] pend_nxt,
  output logic [SRC_PER_CH-1:0] irq,
  output logic                  rxf_req,
  output logic                  txe_req
);
  logic [FLAG_CNT-1:0] ack_v;
  logic [FLAG_CNT-1:0] fn;

  // acks only count while the matching request is up
  always_comb begin
    ack_v        = '0;
    ack_v[F_RXF] = rxf_ack & rxf_req;
    ack_v[F_TXE] = txe_ack & txe_req;
  end

  for (genvar f = 0; f < FLAG_CNT; f++) begin : g_flag
    uart_irq_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set_p(set_v[f]),
      .clr_p(clr_v[f]),
      .ack_p(ack_v[f]),
      .nxt  (fn[f]),
      .q    (flg[f])
    );
  end

  always_comb begin
    pend_nxt          = '0;
    pend_nxt[SRC_ERR] = (fn[F_OVR] | fn[F_PAR] | fn[F_FRM]) & en_rx;
    pend_nxt[SRC_RXF] = fn[F_RXF] & en_rx;
    pend_nxt[SRC_TXE] = fn[F_TXE] & en_txe;
    pend_nxt[SRC_TXD] = fn[F_TXD] & en_txd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= '0;
      rxf_req <= 1'b0;
      txe_req <= 1'b0;
    end else begin
      irq     <= pend_nxt;
      rxf_req <= pend_nxt[SRC_RXF];
      txe_req <= pend_nxt[SRC_TXE];
    end
  end
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb #(
  parameter int N = 12,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  output logic         vld,
  output logic [W-1:0] vec
);
  logic [W-1:0] win;

  // lowest index pending wins
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) win = W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      vec <= '0;
    end else begin
      vld <= |pend;
      vec <= win;
    end
  end
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
  import uart_irq_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NCH-1:0]                set_ovr,
  input  logic [NCH-1:0]                set_par,
  input  logic [NCH-1:0]                set_frm,
  input  logic [NCH-1:0]                set_rxf,
  input  logic [NCH-1:0]                set_txe,
  input  logic [NCH-1:0]                set_txd,
  input  logic [NCH-1:0]                clr_ovr,
  input  logic [NCH-1:0]                clr_par,
  input  logic [NCH-1:0]                clr_frm,
  input  logic [NCH-1:0]                clr_rxf,
  input  logic [NCH-1:0]                clr_txe,
  input  logic [NCH-1:0]                clr_txd,
  input  logic [NCH-1:0]                en_rx,
  input  logic [NCH-1:0]                en_txe,
  input  logic [NCH-1:0]                en_txd,
  input  logic [NCH-1:0]                rxf_ack,
  input  logic [NCH-1:0]                txe_ack,
  output logic [NCH-1:0]                flg_ovr,
  output logic [NCH-1:0]                flg_par,
  output logic [NCH-1:0]                flg_frm,
  output logic [NCH-1:0]                flg_rxf,
  output logic [NCH-1:0]                flg_txe,
  output logic [NCH-1:0]                flg_txd,
  output logic [NCH-1:0]                irq_err,
  output logic [NCH-1:0]                irq_rxf,
  output logic [NCH-1:0]                irq_txe,
  output logic [NCH-1:0]                irq_txd,
  output logic [NCH-1:0]                rxf_req,
  output logic [NCH-1:0]                txe_req,
  output logic                          irq_valid,
  output logic [$clog2(NCH*4)-1:0]      irq_vec
);
  localparam int NSRC  = NCH * SRC_PER_CH;
  localparam int VEC_W = $clog2(NSRC);

  logic [NSRC-1:0] pend_all;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [FLAG_CNT-1:0]   set_v, clr_v, flg;
    logic [SRC_PER_CH-1:0] pn, irq;

    assign set_v = {set_txd[c], set_txe[c], set_rxf[c], set_frm[c], set_par[c], set_ovr[c]};
    assign clr_v = {clr_txd[c], clr_txe[c], clr_rxf[c], clr_frm[c], clr_par[c], clr_ovr[c]};

    uart_irq_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .set_v   (set_v),
      .clr_v   (clr_v),
      .en_rx   (en_rx[c]),
      .en_txe  (en_txe[c]),
      .en_txd  (en_txd[c]),
      .rxf_ack (rxf_ack[c]),
      .txe_ack (txe_ack[c]),
      .flg     (flg),
      .pend_nxt(pn),
      .irq     (irq),
      .rxf_req (rxf_req[c]),
      .txe_req (txe_req[c])
    );

    assign pend_all[c*SRC_PER_CH +: SRC_PER_CH] = pn;

    assign flg_ovr[c] = flg[F_OVR];
    assign flg_par[c] = flg[F_PAR];
    assign flg_frm[c] = flg[F_FRM];
    assign flg_rxf[c] = flg[F_RXF];
    assign flg_txe[c] = flg[F_TXE];
    assign flg_txd[c] = flg[F_TXD];
    assign irq_err[c] = irq[SRC_ERR];
    assign irq_rxf[c] = irq[SRC_RXF];
    assign irq_txe[c] = irq[SRC_TXE];
    assign irq_txd[c] = irq[SRC_TXD];
  end

  uart_irq_arb #(.N(NSRC), .W(VEC_W)) u_arb (
    .clk (clk),
    .rst (rst),
    .pend(pend_all),
    .vld (irq_valid),
    .vec (irq_vec)
  );
endmodule

// File: rtl/uart_irq_hub_chk.sv
module uart_irq_hub_chk #(
  parameter int NCH = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NCH-1:0]           set_ovr, set_par, set_frm, set_rxf, set_txe, set_txd,
  input logic [NCH-1:0]           clr_ovr, clr_par, clr_frm, clr_rxf, clr_txe, clr_txd,
  input logic [NCH-1:0]           en_rx, en_txe, en_txd,
  input logic [NCH-1:0]           rxf_ack, txe_ack,
  input logic [NCH-1:0]           flg_ovr, flg_par, flg_frm, flg_rxf, flg_txe, flg_txd,
  input logic [NCH-1:0]           irq_err, irq_rxf, irq_txe, irq_txd,
  input logic [NCH-1:0]           rxf_req, txe_req,
  input logic                     irq_valid,
  input logic [$clog2(NCH*4)-1:0] irq_vec
);
  localparam int NSRC = NCH * 4;

  logic [NSRC-1:0] irq_all;
  logic [NSRC-1:0] below;
  logic [NSRC-1:0] one_v;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      irq_all[c*4 + 0] = irq_err[c];
      irq_all[c*4 + 1] = irq_rxf[c];
      irq_all[c*4 + 2] = irq_txe[c];
      irq_all[c*4 + 3] = irq_txd[c];
    end
    one_v = NSRC'(1);
    below = irq_all & ((one_v << irq_vec) - one_v);
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) && !rst |-> !irq_valid && irq_vec == '0 && irq_all == '0); // R1

  AST_VALID_ANY: assert property (@(posedge clk) disable iff (rst)
    irq_valid == (|irq_all)); // R9

  AST_VEC_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_all[irq_vec]); // R9

  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> below == '0); // R12

  for (genvar c = 0; c < NCH; c++) begin : g_c
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
      set_txe[c] |=> flg_txe[c]); // R2

    AST_TXE_GATED: assert property (@(posedge clk) disable iff (rst)
      irq_txe[c] |-> flg_txe[c] && $past(en_txe[c])); // R3

    AST_TXD_GATED: assert property (@(posedge clk) disable iff (rst)
      irq_txd[c] |-> flg_txd[c] && $past(en_txd[c])); // R4

    AST_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
      irq_err[c] |-> (flg_ovr[c] | flg_par[c] | flg_frm[c]) && $past(en_rx[c])); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      txe_req[c] && txe_ack[c] && !set_txe[c] |=> !flg_txe[c] && !txe_req[c]); // R7

    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
      !rxf_req[c] && flg_rxf[c] && rxf_ack[c] && !clr_rxf[c] |=> flg_rxf[c]); // R7

    AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
      rxf_req[c] && rxf_ack[c] && set_rxf[c] |=> flg_rxf[c]); // R8

    AST_TXE_FIRST: assert property (@(posedge clk) disable iff (rst)
      irq_txe[c] |-> irq_vec != ($clog2(NCH*4))'(c*4 + 3)); // R10

    AST_PAIR_CLEAR: assert property (@(posedge clk) disable iff (rst)
      clr_txe[c] && clr_txd[c] && !set_txe[c] && !set_txd[c] |=> !irq_txd[c]); // R11
  end
endmodule

bind uart_irq_hub uart_irq_hub_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_uart_irq_hub.sv
module tb_uart_irq_hub;
  localparam int NCH = 3;
  localparam int VW  = $clog2(NCH*4);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] set_ovr = '0, set_par = '0, set_frm = '0, set_rxf = '0, set_txe = '0, set_txd = '0;
  logic [NCH-1:0] clr_ovr = '0, clr_par = '0, clr_frm = '0, clr_rxf = '0, clr_txe = '0, clr_txd = '0;
  logic [NCH-1:0] en_rx = '0, en_txe = '0, en_txd = '0;
  logic [NCH-1:0] rxf_ack = '0, txe_ack = '0;
  logic [NCH-1:0] flg_ovr, flg_par, flg_frm, flg_rxf, flg_txe, flg_txd;
  logic [NCH-1:0] irq_err, irq_rxf, irq_txe, irq_txd, rxf_req, txe_req;
  logic           irq_valid;
  logic [VW-1:0]  irq_vec;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  uart_irq_hub #(.NCH(NCH)) dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // advance to the next falling edge, then drop all pulses
  task automatic tick();
    @(negedge clk);
    set_ovr = '0; set_par = '0; set_frm = '0; set_rxf = '0; set_txe = '0; set_txd = '0;
    clr_ovr = '0; clr_par = '0; clr_frm = '0; clr_rxf = '0; clr_txe = '0; clr_txd = '0;
    rxf_ack = '0; txe_ack = '0;
  endtask

  task automatic wipe();
    clr_ovr = '1; clr_par = '1; clr_frm = '1; clr_rxf = '1; clr_txe = '1; clr_txd = '1;
    en_rx = '0; en_txe = '0; en_txd = '0;
    tick();
    tick();
  endtask

  task automatic t_reset();
    chk("R1 flags", int'({flg_ovr, flg_par, flg_frm, flg_rxf, flg_txe, flg_txd}), 0);
    chk("R1 irqs", int'({irq_err, irq_rxf, irq_txe, irq_txd}), 0);
    chk("R1 reqs", int'({rxf_req, txe_req}), 0);
    chk("R1 valid", int'(irq_valid), 0);
    chk("R1 vec", int'(irq_vec), 0);
  endtask

  task automatic t_flag_rules();
    set_txe[1] = 1'b1; tick();
    chk("R2 set", int'(flg_txe), 3'b010);
    chk("R3 txe gated off", int'(irq_txe), 0);
    en_txe[1] = 1'b1; tick();
    chk("R3 txe on", int'(irq_txe), 3'b010);
    chk("R9 vec ch1 txe", int'(irq_vec), 6);
    chk("R9 valid", int'(irq_valid), 1);
    clr_txe[1] = 1'b1; tick();
    chk("R2 clear", int'(flg_txe), 0);
    chk("R9 valid drop", int'(irq_valid), 0);
    set_txe[1] = 1'b1; clr_txe[1] = 1'b1; tick();
    chk("R2 set beats clear", int'(flg_txe), 3'b010);
    wipe();
  endtask

  task automatic t_rx_err();
    en_rx[2] = 1'b1; set_par[2] = 1'b1; tick();
    chk("R5 err parity", int'(irq_err), 3'b100);
    chk("R9 vec ch2 err", int'(irq_vec), 8);
    chk("R6 no rxf req from err", int'(rxf_req), 0);
    clr_par[2] = 1'b1; tick();
    chk("R5 err gone", int'(irq_err), 0);
    en_rx[2] = 1'b0; set_ovr[2] = 1'b1; tick();
    chk("R5 flag kept", int'(flg_ovr), 3'b100);
    chk("R5 err gated off", int'(irq_err), 0);
    en_rx[2] = 1'b1; tick();
    chk("R5 err overrun", int'(irq_err), 3'b100);
    set_rxf[1] = 1'b1; en_rx[1] = 1'b1; tick();
    chk("R3 rxf on", int'(irq_rxf), 3'b010);
    chk("R9 vec ch1 rxf", int'(irq_vec), 5);
    wipe();
  endtask

  task automatic t_txd();
    set_txd[0] = 1'b1; en_txe[0] = 1'b1; tick();
    chk("R4 txd gated off", int'(irq_txd), 0);
    en_txd[0] = 1'b1; tick();
    chk("R4 txd on", int'(irq_txd), 3'b001);
    chk("R9 vec ch0 txd", int'(irq_vec), 3);
    chk("R6 no reqs from txd", int'({rxf_req, txe_req}), 0);
    wipe();
  endtask

  task automatic t_tx_pair();
    en_txe[0] = 1'b1; en_txd[0] = 1'b1;
    set_txe[0] = 1'b1; set_txd[0] = 1'b1; tick();
    chk("R10 both pending txd", int'(irq_txd), 3'b001);
    chk("R10 txe wins", int'(irq_vec), 2);
    clr_txe[0] = 1'b1; clr_txd[0] = 1'b1; tick();
    chk("R11 no txd after pair clear", int'(irq_txd), 0);
    chk("R11 nothing pending", int'(irq_valid), 0);
    set_txe[0] = 1'b1; set_txd[0] = 1'b1; tick();
    clr_txe[0] = 1'b1; tick();
    chk("R10 txd after txe cleared", int'(irq_vec), 3);
    wipe();
  endtask

  task automatic t_chan_order();
    en_rx = '1; en_txd[0] = 1'b1;
    set_rxf[2] = 1'b1; set_ovr[1] = 1'b1; set_txd[0] = 1'b1; tick();
    chk("R12 ch0 first", int'(irq_vec), 3);
    clr_txd[0] = 1'b1; tick();
    chk("R12 ch1 next", int'(irq_vec), 4);
    clr_ovr[1] = 1'b1; tick();
    chk("R12 ch2 last", int'(irq_vec), 9);
    clr_rxf[2] = 1'b1; tick();
    chk("R9 valid low", int'(irq_valid), 0);
    wipe();
  endtask

  task automatic t_xfer();
    en_rx[1] = 1'b1; set_rxf[1] = 1'b1; tick();
    chk("R6 rxf req", int'(rxf_req), 3'b010);
    rxf_ack[1] = 1'b1; tick();
    chk("R7 ack clears flag", int'(flg_rxf), 0);
    chk("R7 req drops", int'(rxf_req), 0);
    chk("R7 irq drops", int'(irq_rxf), 0);
    set_txe[0] = 1'b1; tick();
    chk("R6 req gated off", int'(txe_req), 0);
    txe_ack[0] = 1'b1; tick();
    chk("R7 stray ack ignored", int'(flg_txe), 3'b001);
    en_txe[0] = 1'b1; tick();
    chk("R6 txe req", int'(txe_req), 3'b001);
    txe_ack[0] = 1'b1; set_txe[0] = 1'b1; tick();
    chk("R8 set beats ack flag", int'(flg_txe), 3'b001);
    chk("R8 set beats ack req", int'(txe_req), 3'b001);
    txe_ack[0] = 1'b1; tick();
    chk("R7 txe ack clears", int'({flg_txe, txe_req}), 0);
    en_rx[2] = 1'b1; en_txd[2] = 1'b1; set_frm[2] = 1'b1; set_txd[2] = 1'b1; tick();
    chk("R6 err and txd pending", int'({irq_err[2], irq_txd[2]}), 2'b11);
    chk("R6 no reqs", int'({rxf_req, txe_req}), 0);
    wipe();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_flag_rules();
    t_rx_err();
    t_txd();
    t_tx_pair();
    t_chan_order();
    t_xfer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule